// File: doc/BRIEF.md
# Filtered Quadrature Position Counter with Gated Index

This block turns the two phase lines of an incremental encoder into a signed 32-bit position count. Each of the four input lines (phase A, phase B, index and index mask) passes through a two-flop synchronizer. It then passes through a persistence filter, so that short glitches never reach the decoder. The filter length is chosen at run time: a long setting of 15 sample clocks or a short setting of 3.

A decoder state machine follows the filtered phase pair. It issues a count step up or down for each legal Gray-code move. In the alternative single-input mode, it steps once on each rising edge of phase A, and the level of phase B sets the direction. Two counts are kept. The position count can be forced to zero by a level-sensitive clear input. It can also be forced to zero by an armed index event. The raw count accumulates every step since power-up and is never cleared.

An index state machine holds the arm flag. It has two states. In IDX_IDLE it waits for an arm request. The transition arm → IDX_ARMED takes place on a cycle with the request high. In IDX_ARMED it waits for a qualifying index edge. The transition fire → IDX_IDLE takes place on that edge, in the same cycle that the position count is zeroed. A qualifying edge is the filtered index edge selected by the polarity bit. When masking is enabled, the filtered mask line must also sit at its selected active level.

The phase decoder has four states, one per filtered {A,B} level pair: PH_00, PH_10, PH_11 and PH_01. Every cycle it moves to the state of the current pair. The forward moves PH_00→PH_10→PH_11→PH_01→PH_00 give up steps, the reverse moves give down steps, and a diagonal move gives no step.

Top module: `quad_index_counter`

## Requirements
- R1: With `cfg_long_filter` high, a phase-A pulse held for 14 clocks produces no count, and one held for 15 clocks is accepted.
- R2: With `cfg_long_filter` low, a phase-A pulse of 2 clocks produces no count, and one of 3 clocks is accepted.
- R3: In quadrature mode (`cfg_updown` low), the {A,B} sequence 00→10→11→01→00 adds one count per move, and the reverse sequence subtracts one per move.
- R4: In quadrature mode, a move in which filtered A and B both change leaves both counts unchanged.
- R5: With `cfg_updown` high, the counts step only on a rising edge of filtered A: up when B is low, down when B is high. Falling edges of A and any change of B do not step.
- R6: An `arm_req` pulse sets `armed_o`. While armed, a qualifying index edge sets `count_o` to zero and clears `armed_o` on the same clock edge. While not armed, index edges have no effect on the count.
- R7: `cfg_idx_rise` high selects the rising edge of the filtered index line as the trigger. Low selects the falling edge. The opposite edge does not fire.
- R8: With `cfg_mask_en` high, an index edge qualifies only when filtered `pin_mask` equals `cfg_mask_high`.
- R9: While `clr_count` is high, `count_o` reads zero one clock later and stays zero, even if steps arrive. After release, counting resumes from zero.
- R10: `raw_o` accumulates every step and is not affected by `clr_count` or by index events.
- R11: Both counts are 32-bit two's complement and wrap, so one down step from zero reads 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Encoder phase A (asynchronous) |
| pin_b | input | 1 | Encoder phase B (asynchronous) |
| pin_idx | input | 1 | Encoder index line (asynchronous) |
| pin_mask | input | 1 | Index mask line (asynchronous) |
| cfg_long_filter | input | 1 | 1: 15-clock filter, 0: 3-clock filter |
| cfg_updown | input | 1 | 1: single-input step/direction mode, 0: quadrature |
| cfg_idx_rise | input | 1 | 1: rising index edge triggers, 0: falling edge |
| cfg_mask_en | input | 1 | Require the mask line at its active level |
| cfg_mask_high | input | 1 | Active level of the mask line |
| arm_req | input | 1 | Arm the index clear |
| clr_count | input | 1 | Level clear of the position count |
| count_o | output | 32 | Position count |
| raw_o | output | 32 | Raw count, never cleared |
| armed_o | output | 1 | Index clear is armed |

## Verification
A stuck or mis-encoded phase state shows on `count_o` and `raw_o` as a missing step, a step in the wrong direction, or a step on a diagonal move. This shows at most one clock after the filtered move, which is about 5 clocks after a pin change with the short filter and 17 with the long one. A filter counter that is off by one shows as a pulse of boundary width being accepted or rejected. A fault in the index state machine or in its edge logic shows on `armed_o` and `count_o` in the clock after the filtered index edge: the count is either not zeroed, or zeroed while unarmed or masked. Every change of `count_o` that differs from the change of `raw_o` must come from a clear or an index fire, so a corrupted position register is caught on the next clock.

// File: rtl/qic_pkg.sv
package qic_pkg;
    // Decoder state encodes the filtered {A,B} pair directly.
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_t;

    typedef enum logic {
        IDX_IDLE  = 1'b0,
        IDX_ARMED = 1'b1
    } idx_state_t;

    localparam int unsigned NUM_LINES = 4;
    localparam int unsigned LINE_A    = 0;
    localparam int unsigned LINE_B    = 1;
    localparam int unsigned LINE_IDX  = 2;
    localparam int unsigned LINE_MASK = 3;
endpackage

// File: rtl/qic_line_filter.sv
module qic_line_filter #(
    parameter int unsigned LONG_LEN  = 15,
    parameter int unsigned SHORT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic long_sel,
    output logic level_o
);
    localparam int unsigned CW = $clog2(LONG_LEN + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);

    logic          meta_q, sync_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] last;

    assign last = long_sel ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    // Accept a new level on the Nth consecutive differing sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_o <= 1'b0;
        end else if (sync_q == level_o) begin
            run_q <= '0;
        end else if (run_q >= last) begin
            run_q   <= '0;
            level_o <= sync_q;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/qic_phase_decoder.sv
module qic_phase_decoder
    import qic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_f,
    input  logic b_f,
    input  logic updown,
    output logic step_up,
    output logic step_dn
);
    phase_t state_q, now;

    assign now = phase_t'({a_f, b_f});

    // State register: follows the filtered pair every clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= now;
    end

    // Output logic.
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        if (updown) begin
            if (!state_q[1] && a_f) begin
                step_up = !b_f;
                step_dn = b_f;
            end
        end else begin
            unique case (state_q)
                PH_00: begin step_up = (now == PH_10); step_dn = (now == PH_01); end
                PH_10: begin step_up = (now == PH_11); step_dn = (now == PH_00); end
                PH_11: begin step_up = (now == PH_01); step_dn = (now == PH_10); end
                PH_01: begin step_up = (now == PH_00); step_dn = (now == PH_11); end
                default: begin step_up = 1'b0; step_dn = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/qic_index_arm.sv
module qic_index_arm
    import qic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idx_f,
    input  logic mask_f,
    input  logic rise_sel,
    input  logic mask_en,
    input  logic mask_high,
    input  logic arm_req,
    output logic fire,
    output logic armed
);
    idx_state_t state_q, state_d;
    logic       idx_prev_q;
    logic       edge_hit, mask_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_prev_q <= 1'b0;
        else        idx_prev_q <= idx_f;
    end

    assign edge_hit = rise_sel ? (idx_f && !idx_prev_q) : (!idx_f && idx_prev_q);
    assign mask_ok  = !mask_en || (mask_f == mask_high);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDX_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            IDX_IDLE: begin
                if (arm_req) state_d = IDX_ARMED;
            end
            IDX_ARMED: begin
                if (edge_hit && mask_ok) begin
                    fire    = 1'b1;
                    state_d = IDX_IDLE;
                end
            end
            default: state_d = IDX_IDLE;
        endcase
    end

    assign armed = (state_q == IDX_ARMED);
endmodule

// File: rtl/quad_index_counter.sv
module quad_index_counter
    import qic_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned LONG_LEN  = 15,
    parameter int unsigned SHORT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             pin_idx,
    input  logic             pin_mask,
    input  logic             cfg_long_filter,
    input  logic             cfg_updown,
    input  logic             cfg_idx_rise,
    input  logic             cfg_mask_en,
    input  logic             cfg_mask_high,
    input  logic             arm_req,
    input  logic             clr_count,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] raw_o,
    output logic             armed_o
);
    logic [NUM_LINES-1:0] pins, lvl;
    logic                 step_up, step_dn, fire;
    logic [CNT_W-1:0]     delta;

    assign pins = {pin_mask, pin_idx, pin_b, pin_a};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        qic_line_filter #(
            .LONG_LEN (LONG_LEN),
            .SHORT_LEN(SHORT_LEN)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_in  (pins[i]),
            .long_sel(cfg_long_filter),
            .level_o (lvl[i])
        );
    end

    qic_phase_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_f    (lvl[LINE_A]),
        .b_f    (lvl[LINE_B]),
        .updown (cfg_updown),
        .step_up(step_up),
        .step_dn(step_dn)
    );

    qic_index_arm u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_f    (lvl[LINE_IDX]),
        .mask_f   (lvl[LINE_MASK]),
        .rise_sel (cfg_idx_rise),
        .mask_en  (cfg_mask_en),
        .mask_high(cfg_mask_high),
        .arm_req  (arm_req),
        .fire     (fire),
        .armed    (armed_o)
    );

    assign delta = step_up ? CNT_W'(1) : (step_dn ? {CNT_W{1'b1}} : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
            raw_o   <= '0;
        end else begin
            raw_o <= raw_o + delta;
            if (clr_count || fire) count_o <= '0;
            else                   count_o <= count_o + delta;
        end
    end
endmodule

// File: rtl/qic_checker.sv
module qic_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_req,
    input logic             clr_count,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] raw_o,
    input logic             armed_o
);
    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_count |=> (count_o == '0)); // R9

    AST_FIRE_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed_o) |-> (count_o == '0)); // R6

    AST_ARM_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(arm_req)); // R6

    AST_RAW_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_o - $past(raw_o)) == '0) || ((raw_o - $past(raw_o)) == CNT_W'(1))
        || ((raw_o - $past(raw_o)) == {CNT_W{1'b1}})); // R10

    AST_COUNT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_count |=> ($fell(armed_o)
        || ((count_o - $past(count_o)) == (raw_o - $past(raw_o))))); // R10
endmodule

bind quad_index_counter qic_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_req  (arm_req),
    .clr_count(clr_count),
    .count_o  (count_o),
    .raw_o    (raw_o),
    .armed_o  (armed_o)
);

// File: tb/quad_index_counter_tb.sv
module quad_index_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_a = 0, pin_b = 0, pin_idx = 0, pin_mask = 0;
    logic        cfg_long_filter = 0, cfg_updown = 0, cfg_idx_rise = 1;
    logic        cfg_mask_en = 0, cfg_mask_high = 1;
    logic        arm_req = 0, clr_count = 0;
    logic [31:0] count_o, raw_o;
    logic        armed_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_cnt = 0, exp_raw = 0;

    localparam int SETTLE = 25;

    // Each entry: {A, B, expected count after settling}. Quadrature mode.
    localparam logic [33:0] VEC [12] = '{
        {2'b10, 32'd1},          // R3 up
        {2'b11, 32'd2},          // R3
        {2'b01, 32'd3},          // R3
        {2'b00, 32'd4},          // R3
        {2'b01, 32'd3},          // R3 down
        {2'b11, 32'd2},          // R3
        {2'b10, 32'd1},          // R3
        {2'b00, 32'd0},          // R3
        {2'b01, 32'hFFFF_FFFF},  // R11 wrap below zero
        {2'b10, 32'hFFFF_FFFF},  // R4 diagonal move
        {2'b00, 32'hFFFF_FFFE},  // R3 down
        {2'b11, 32'hFFFF_FFFE}   // R4 diagonal move
    };

    always #5 clk = ~clk;

    quad_index_counter u_dut (
        .clk(clk), .rst_n(rst_n),
        .pin_a(pin_a), .pin_b(pin_b), .pin_idx(pin_idx), .pin_mask(pin_mask),
        .cfg_long_filter(cfg_long_filter), .cfg_updown(cfg_updown),
        .cfg_idx_rise(cfg_idx_rise), .cfg_mask_en(cfg_mask_en),
        .cfg_mask_high(cfg_mask_high), .arm_req(arm_req), .clr_count(clr_count),
        .count_o(count_o), .raw_o(raw_o), .armed_o(armed_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic arm();
        @(negedge clk); arm_req = 1;
        @(negedge clk); arm_req = 0;
    endtask

    task automatic pulse_a(input int w);
        @(negedge clk); pin_a = 1;
        repeat (w) @(negedge clk);
        pin_a = 0;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset count", count_o, 0);
        chk("R10 reset raw", raw_o, 0);
        chk("R6 reset armed", 32'(armed_o), 0);
        rst_n = 1;
        settle();

        foreach (VEC[i]) begin
            pin_a = VEC[i][33];
            pin_b = VEC[i][32];
            settle();
            chk($sformatf("R3/R4/R11 vector %0d count", i), count_o, VEC[i][31:0]);
        end
        chk("R10 raw after vectors", raw_o, 32'hFFFF_FFFE);
        exp_raw = 32'hFFFF_FFFE;

        // Level clear (position 11).
        @(negedge clk); clr_count = 1;
        settle();
        chk("R9 clear zeroes count", count_o, 0);
        pin_a = 0; pin_b = 1; settle();           // 11 -> 01 up
        exp_raw = exp_raw + 1;
        chk("R9 count held during clear", count_o, 0);
        chk("R10 raw counts during clear", raw_o, exp_raw);
        @(negedge clk); clr_count = 0;
        pin_b = 0; settle();                      // 01 -> 00 up
        exp_raw = exp_raw + 1;
        chk("R9 resume from zero", count_o, 1);

        // Index: rising edge, armed.
        pin_a = 1; settle();                      // 00 -> 10 up
        exp_raw = exp_raw + 1;
        chk("R3 count before index", count_o, 2);
        arm();
        chk("R6 armed after request", 32'(armed_o), 1);
        pin_idx = 1; settle();
        chk("R6 index clears count", count_o, 0);
        chk("R6 index disarms", 32'(armed_o), 0);
        chk("R10 raw unaffected by index", raw_o, exp_raw);
        pin_idx = 0; settle();

        // Unarmed index has no effect.
        pin_b = 1; settle();                      // 10 -> 11 up
        exp_raw = exp_raw + 1;
        pin_idx = 1; settle(); pin_idx = 0; settle();
        chk("R6 unarmed index ignored", count_o, 1);

        // Falling-edge polarity.
        cfg_idx_rise = 0;
        arm();
        pin_idx = 1; settle();
        chk("R7 rising edge ignored when falling selected", count_o, 1);
        chk("R7 still armed", 32'(armed_o), 1);
        pin_idx = 0; settle();
        chk("R7 falling edge fires", count_o, 0);
        chk("R7 disarmed", 32'(armed_o), 0);

        // Mask, active high.
        cfg_idx_rise = 1; cfg_mask_en = 1; cfg_mask_high = 1; pin_mask = 0;
        pin_a = 0; settle();                      // 11 -> 01 up
        exp_raw = exp_raw + 1;
        arm();
        pin_idx = 1; settle();
        chk("R8 masked edge ignored", count_o, 1);
        chk("R8 still armed", 32'(armed_o), 1);
        pin_idx = 0; pin_mask = 1; settle();
        pin_idx = 1; settle();
        chk("R8 unmasked edge fires", count_o, 0);
        pin_idx = 0; settle();

        // Mask, active low.
        cfg_mask_high = 0;
        pin_b = 0; settle();                      // 01 -> 00 up
        exp_raw = exp_raw + 1;
        arm();
        pin_idx = 1; settle();
        chk("R8 active-low mask blocks when high", count_o, 1);
        pin_idx = 0; pin_mask = 0; settle();
        pin_idx = 1; settle();
        chk("R8 active-low mask passes when low", count_o, 0);
        pin_idx = 0; cfg_mask_en = 0; settle();
        chk("R10 raw after index tests", raw_o, exp_raw);

        // Single-input mode and filter lengths (A=0, B=0).
        cfg_updown = 1;
        exp_cnt = count_o;
        pulse_a(2);
        chk("R2 short filter rejects 2 clocks", count_o, exp_cnt);
        pulse_a(3);
        exp_cnt = exp_cnt + 1;
        chk("R2/R5 short filter accepts 3 clocks, B low up", count_o, exp_cnt);
        pin_b = 1; settle();
        chk("R5 B change does not step", count_o, exp_cnt);
        pulse_a(3);
        exp_cnt = exp_cnt - 1;
        chk("R5 B high steps down", count_o, exp_cnt);
        pin_b = 0; settle();
        cfg_long_filter = 1;
        pulse_a(14);
        chk("R1 long filter rejects 14 clocks", count_o, exp_cnt);
        pulse_a(15);
        exp_cnt = exp_cnt + 1;
        chk("R1 long filter accepts 15 clocks", count_o, exp_cnt);

        finish_run();
    end
endmodule